// File: doc/BRIEF.md
# Serial TDM Interface Power-Down Controller

This block owns the timing of a framed serial TDM link that carries a frame strobe, a double-rate data clock, a bit clock and one downstream data line. In each frame it reads a 4-bit command/indicate code from the upstream data line. When clock shutdown is allowed and the far end keeps asking for deactivation, it acknowledges by sending a deactivate code downstream for four frames. It then halts every timing output exactly at the end of the command field of the fourth acknowledge frame and parks all outputs at their idle levels.

While stopped, the block waits for a wake-up event. The events are a software power-up request, the upstream line pulled low, the clock-shutdown enable being cleared, or line activity when line detection is not disabled. It then lets a programmable oscillator start-up delay run out. Timing resumes with the bit that follows the command field, so the far end sees no phase jump. A status output reports the controller state and the acknowledge frame count.

A frame has `BITS` bit slots. Each bit lasts four reference clock cycles, which gives two data-clock periods per bit. The command field occupies bits `CI_POS` to `CI_POS+3`, most significant bit first.

Top module: `iom_pwrdn_ctl`

## Requirements
- R1: While stopped (mode 2), fsc is 1, dcl is 0, bcl is 0 and dd is 1.
- R2: Under reset the controller is active (mode 0, ack_num 0), positioned at phase 0 of bit 0: fsc, dcl and bcl read 1 and dd reads 1.
- R3: While the clocks run, each bit lasts four reference cycles. dcl is high in phases 0 and 2 and bcl is high in phases 0 and 1. fsc is high for all of bit 0. A frame holds `2*BITS` dcl rising edges.
- R4: The upstream code is sampled in phase 1 of bits `CI_POS`..`CI_POS+3`, MSB first. It is accepted only when the same value arrives in two consecutive frames. The last accepted value is kept until the next acceptance or a wake-up.
- R5: At the last cycle of a frame in mode 0, the controller enters acknowledge with count 1 if cfs is 1, line_act is 0 and the accepted code is 1111. Otherwise it stays active.
- R6: In the command field, dd carries ACT_CODE (default 1100) in mode 0 and DEACT_CODE (default 1111) in mode 1, MSB first. Every other bit slot carries 1.
- R7: ack_num counts 1 to 4 across the acknowledge frames and is 0 outside mode 1. In the fourth frame the clocks stop after the last command bit, so that frame shows `2*(CI_POS+4)-1` dcl rises after its first one.
- R8: In mode 2, any one of spu=1, du=0, cfs=0, or line_act=1 with ldd=0 moves the controller to mode 3. line_act=1 with ldd=1 has no effect.
- R9: Mode 0 resumes `OSC_CYC+1` reference-clock edges after the wake-up event is first presented.
- R10: On resume, dcl and bcl rise at the start of bit `CI_POS+4`. The next fsc rise comes `2*(BITS-CI_POS-4)` dcl rises later. The command history is cleared, so two fresh matching frames are needed again.
- R11: Status mode encodes 0 active, 1 acknowledging, 2 stopped and 3 waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, four cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| cfs | input | 1 | Clock shutdown enable (1 allows stopping) |
| ldd | input | 1 | Line-detect disable for wake-up |
| spu | input | 1 | Software power-up request |
| line_act | input | 1 | Line activity present |
| du | input | 1 | Upstream serial data |
| fsc | output | 1 | Frame strobe |
| dcl | output | 1 | Data clock, twice the bit rate |
| bcl | output | 1 | Bit clock |
| dd | output | 1 | Downstream serial data |
| mode | output | 2 | Controller state |
| ack_num | output | 3 | Acknowledge frame number, 0 outside acknowledge |

## Verification
The assertions assume that cfs, line_act, ldd and du change only away from clock edges. They also assume that while the controller is stopped, nothing other than the deliberate wake-up event leaves its idle value. The stimulus meets this by driving every input on the falling clock edge. It changes cfs, line_act and ldd only at frame starts, and it holds spu low, du high and line_act low through the acknowledge and stopped phases until the chosen wake-up source is applied.

// File: rtl/iom_pwrdn_ctl.sv
module iom_pwrdn_ctl #(
  parameter int BITS = 96,
  parameter int CI_POS = 26,
  parameter int OSC_CYC = 2000,
  parameter logic [3:0] ACT_CODE = 4'b1100,
  parameter logic [3:0] DEACT_CODE = 4'b1111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfs,
  input  logic       ldd,
  input  logic       spu,
  input  logic       line_act,
  input  logic       du,
  output logic       fsc,
  output logic       dcl,
  output logic       bcl,
  output logic       dd,
  output logic [1:0] mode,
  output logic [2:0] ack_num
);
  localparam int BW = $clog2(BITS);
  localparam int CI_END = CI_POS + 3;
  localparam int RESUME = CI_POS + 4;
  localparam int OW = $clog2(OSC_CYC + 1);

  typedef enum logic [1:0] {S_ACT = 2'd0, S_ACK = 2'd1, S_OFF = 2'd2, S_WAKE = 2'd3} st_t;

  st_t st;
  logic [1:0] ph;
  logic [BW-1:0] bit_cnt;
  logic [2:0] ack;
  logic [2:0] rx;
  logic [3:0] prev, acc;
  logic prev_vld, acc_vld;
  logic [OW-1:0] osc;

  wire running = (st == S_ACT) || (st == S_ACK);
  wire frame_end = (bit_cnt == BW'(BITS - 1)) && (ph == 2'd3);
  wire ci_bit = (bit_cnt >= BW'(CI_POS)) && (bit_cnt <= BW'(CI_END));
  wire ci_last = (bit_cnt == BW'(CI_END));
  wire [3:0] code = {rx, du};
  wire shut = cfs && !line_act && acc_vld && (acc == 4'hF);
  wire wake = spu || !du || !cfs || (line_act && !ldd);
  wire [3:0] txc = (st == S_ACK) ? DEACT_CODE : ACT_CODE;

  logic dd_ci;
  always_comb begin
    dd_ci = 1'b1;
    for (int i = 0; i < 4; i++)
      if (bit_cnt == BW'(CI_POS + i)) dd_ci = txc[3-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_ACT;
      ph <= '0;
      bit_cnt <= '0;
      ack <= '0;
      rx <= '0;
      prev <= '0;
      acc <= '0;
      prev_vld <= 1'b0;
      acc_vld <= 1'b0;
      osc <= '0;
    end else begin
      case (st)
        S_ACT, S_ACK: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
          if (ph == 2'd1 && ci_bit) begin
            rx <= code[2:0];
            if (ci_last) begin
              if (prev_vld && code == prev) begin
                acc <= code;
                acc_vld <= 1'b1;
              end
              prev <= code;
              prev_vld <= 1'b1;
            end
          end
          if (st == S_ACT && frame_end && shut) begin
            st <= S_ACK;
            ack <= 3'd1;
          end
          if (st == S_ACK && frame_end) ack <= ack + 3'd1;
          if (st == S_ACK && ack == 3'd4 && ci_last && ph == 2'd3) begin
            st <= S_OFF;
            ack <= '0;
            bit_cnt <= BW'(RESUME);
            ph <= '0;
          end
        end
        S_OFF: begin
          if (wake) begin
            st <= S_WAKE;
            osc <= OW'(OSC_CYC - 1);
            prev_vld <= 1'b0;
            acc_vld <= 1'b0;
          end
        end
        default: begin
          if (osc == '0) st <= S_ACT;
          else osc <= osc - 1'b1;
        end
      endcase
    end
  end

  assign fsc = running ? (bit_cnt == '0) : 1'b1;
  assign dcl = running && !ph[0];
  assign bcl = running && !ph[1];
  assign dd = running ? dd_ci : 1'b1;
  assign mode = st;
  assign ack_num = ack;
endmodule

// File: rtl/iom_pwrdn_ctl_chk.sv
module iom_pwrdn_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfs,
  input logic       ldd,
  input logic       spu,
  input logic       line_act,
  input logic       du,
  input logic       fsc,
  input logic       dcl,
  input logic       bcl,
  input logic       dd,
  input logic [1:0] mode,
  input logic [2:0] ack_num
);
  // R1
  idle_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd2 |-> fsc && !dcl && !bcl && dd);
  // R11
  ack_rng_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) == (ack_num >= 3'd1 && ack_num <= 3'd4));
  // R7
  stop_after4_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && $past(mode) == 2'd1) |-> $past(ack_num) == 3'd4);
  // R5
  shut_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(cfs && !line_act));
  // R9
  wake_next_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd3 |=> mode == 2'd3 || mode == 2'd0);
  // R10
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && $past(mode) == 2'd3) |-> dcl && bcl && !fsc);
  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && cfs && du && !spu && !(line_act && !ldd)) |=> mode == 2'd2);
  // R3
  frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[1] == 1'b0 && $rose(fsc)) |-> dcl && bcl);
endmodule

bind iom_pwrdn_ctl iom_pwrdn_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cfs(cfs), .ldd(ldd), .spu(spu), .line_act(line_act),
  .du(du), .fsc(fsc), .dcl(dcl), .bcl(bcl), .dd(dd), .mode(mode), .ack_num(ack_num)
);

// File: tb/iom_pwrdn_ctl_tb.sv
module iom_pwrdn_ctl_tb;
  localparam int BITS = 24;
  localparam int CI_POS = 8;
  localparam int CI_END = CI_POS + 3;
  localparam int RESUME = CI_POS + 4;
  localparam int OSC = 20;
  localparam logic [3:0] ACTC = 4'b1100;
  localparam logic [3:0] DEAC = 4'b1111;

  logic clk = 1'b0, rst = 1'b1;
  logic cfs = 1'b0, ldd = 1'b0, spu = 1'b0, la = 1'b0, du = 1'b1;
  logic fsc, dcl, bcl, dd;
  logic [1:0] mode;
  logic [2:0] ack_num;

  int total = 0, bad = 0, dcl_rises = 0;
  logic [3:0] prev, acc;
  bit prev_v = 0, acc_v = 0;

  always #10 clk = ~clk;
  always @(posedge dcl) dcl_rises++;

  iom_pwrdn_ctl #(.BITS(BITS), .CI_POS(CI_POS), .OSC_CYC(OSC), .ACT_CODE(ACTC), .DEACT_CODE(DEAC)) u_dut (
    .clk(clk), .rst(rst), .cfs(cfs), .ldd(ldd), .spu(spu), .line_act(la), .du(du),
    .fsc(fsc), .dcl(dcl), .bcl(bcl), .dd(dd), .mode(mode), .ack_num(ack_num));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [3:0] code, input int sb, output logic [3:0] got,
                            output bit stp, output int ob);
    got = '1; stp = 0; ob = 0;
    for (int b = sb; b < BITS; b++) begin
      du = (b >= CI_POS && b <= CI_END) ? code[CI_END-b] : 1'b1;
      for (int p = 0; p < 4; p++) begin
        if (mode == 2'd2) begin stp = 1; du = 1'b1; return; end
        if (p == 1) begin
          if (b >= CI_POS && b <= CI_END) got[CI_END-b] = dd;
          else if (dd !== 1'b1) ob++;
        end
        @(negedge clk);
      end
    end
    du = 1'b1;
  endtask

  task automatic wake_up(input int how);
    logic [3:0] got; bit stp; int ob; int n; bit saw;
    ldd = 1; la = 1;
    repeat (10) @(negedge clk);
    chk("R8 ldd blocks line wake", mode, 2);
    chk("R1 idle fsc", fsc, 1);
    chk("R1 idle dcl", dcl, 0);
    la = 0; ldd = 0;
    case (how)
      0: spu = 1;
      1: du = 0;
      2: cfs = 0;
      default: la = 1;
    endcase
    n = 0; saw = 0;
    while (n < OSC + 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mode == 2'd3) begin saw = 1; spu = 0; du = 1; la = 0; end
      if (mode == 2'd0) break;
    end
    chk($sformatf("R8 R11 waking seen src=%0d", how), saw, 1);
    chk("R9 start-up delay", n, OSC + 1);
    chk("R10 dcl at resume", dcl, 1);
    chk("R10 bcl at resume", bcl, 1);
    chk("R10 fsc low at resume", fsc, 0);
    dcl_rises = 0;
    send_frame(4'hF, RESUME, got, stp, ob);
    chk("R10 fsc at next frame", fsc, 1);
    chk("R10 rises to frame", dcl_rises, 2 * (BITS - RESUME));
    prev_v = 0; acc_v = 0;
  endtask

  task automatic ack_seq(input int how);
    logic [3:0] got; bit stp; int ob;
    la = 0; spu = 0; du = 1;
    for (int k = 1; k <= 4; k++) begin
      chk("R7 mode ack", mode, 1);
      chk("R7 ack count", ack_num, k);
      dcl_rises = 0;
      send_frame(4'hF, 0, got, stp, ob);
      chk("R6 deact code", got, DEAC);
      chk("R6 other bits one", ob, 0);
      chk("R7 stop frame", stp, (k == 4) ? 1 : 0);
    end
    chk("R7 stop position", dcl_rises, 2 * RESUME - 1);
    chk("R1 R11 stopped", mode, 2);
    chk("R1 fsc", fsc, 1);
    chk("R1 dcl bcl", {dcl, bcl}, 0);
    chk("R1 dd", dd, 1);
    chk("R7 ack cleared", ack_num, 0);
    wake_up(how);
  endtask

  task automatic frame_step(input logic [3:0] code, input int how);
    logic [3:0] got; bit stp; int ob; bit shut;
    chk("R5 active at frame start", mode, 0);
    chk("R3 fsc at frame start", fsc, 1);
    dcl_rises = 0;
    send_frame(code, 0, got, stp, ob);
    chk("R6 act code", got, ACTC);
    chk("R6 other bits one", ob, 0);
    chk("R3 dcl rises per frame", dcl_rises, 2 * BITS);
    if (prev_v && prev == code) begin acc = code; acc_v = 1; end
    prev = code; prev_v = 1;
    shut = cfs && !la && acc_v && acc == 4'hF;
    chk($sformatf("R4 R5 decision code=%0h", code), mode, shut ? 1 : 0);
    if (shut) ack_seq(how);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R2 mode", mode, 0);
    chk("R2 ack", ack_num, 0);
    chk("R2 clocks", {fsc, dcl, bcl}, 7);
    chk("R2 dd", dd, 1);
    rst = 0;
    frame_step(4'h0, 0);
    frame_step(4'h0, 0);
    cfs = 1;
    frame_step(4'hF, 0);
    frame_step(4'h0, 0);
    frame_step(4'hF, 0);
    frame_step(4'h3, 0);
    la = 1;
    frame_step(4'hF, 0);
    frame_step(4'hF, 0);
    la = 0;
    frame_step(4'h5, 0);
    cfs = 1;
    for (int w = 1; w < 4; w++) begin
      cfs = 1; la = 0;
      frame_step(4'hF, w);
      cfs = 1;
      frame_step(4'hF, w);
    end
    for (int i = 0; i < 60; i++) begin
      int r;
      logic [3:0] c;
      cfs = ($urandom % 4) != 0;
      la = ($urandom % 5) == 0;
      ldd = $urandom % 2;
      r = $urandom % 4;
      c = (r < 2) ? 4'hF : (r == 2 ? 4'h0 : 4'($urandom));
      frame_step(c, $urandom % 4);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule